// File: doc/BRIEF.md
# Serial EEPROM Single-Word Read Controller

This block is a hardware master for three-wire serial EEPROMs that hold 16-bit words and take a start bit, a two-bit opcode and a short address. A request gives a word address and a device-size select. The block drives the select, serial clock and serial output lines through the complete read command and collects the 16 data bits that come back. It then presents the word with a one-cycle completion pulse. The size select chooses a 6-bit address for the smaller part or an 8-bit address for the larger part.

A phase timer divides the system clock. Every change on a serial line is held for `PHASE_CYC` system cycles before the next change. A sequencer steps through the transaction phases. It starts with select setup and a leading clock pulse. Then comes one setup phase and one clock pulse for each command and address bit. The output line is forced low during 16 read pulses. Select is then released and one trailing pulse closes the transaction. The block performs single-word reads only.

Top module: `sprom_word_reader`

## Requirements
- R1: A start seen while idle is accepted at that clock edge, and busy is high from the next cycle. The first bits shifted out are the command 1, 1, 0, in that order.
- R2: The word address follows the command, most significant bit first. With the size select low it is addr[5:0] (6 bits, addr[7:6] ignored). With the size select high it is addr[7:0] (8 bits).
- R3: After select rises, it is held with the clock and output low for one phase. One full clock pulse with the output low follows before the first command bit is presented.
- R4: Each command or address bit is placed on the serial output for one phase with the clock low. It then stays unchanged through one clock-high phase and one clock-low phase. The serial output never changes in a cycle where the clock is high or has just fallen.
- R5: After the last address bit, the serial output is low for one phase and stays low through exactly 16 clock pulses. The serial input is sampled at the end of each pulse's low phase. The first sample lands in bit 15 and the last in bit 0, so the device's dummy zero is never captured.
- R6: After the 16th sample, select falls and stays low for one phase. One more full clock pulse with select low is then issued.
- R7: Every phase lasts exactly `PHASE_CYC` cycles. Busy is therefore high for `PHASE_CYC*(48+3*N)` cycles, where N is the address length (6 or 8).
- R8: Done is high for exactly one cycle, right after the trailing pulse, with busy low. The data output takes the read word in that cycle and keeps it until the next completion.
- R9: A start, address or size select applied while busy has no effect on the transaction in progress.
- R10: During reset and while idle, select, serial clock, serial output, busy and done are low. Reset clears the data output to zero. Reset is asynchronous in assertion and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a word read (taken only when idle) |
| addr_i | input | ADDR_W | Word address |
| dev_large_i | input | 1 | 1 selects the 8-bit address part, 0 the 6-bit part |
| ser_in_i | input | 1 | Serial data returned by the memory |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Last word read |
| ser_sel_o | output | 1 | Memory select |
| ser_clk_o | output | 1 | Serial clock |
| ser_out_o | output | 1 | Serial command and address data |

## Verification
The bench memory model drives a dummy zero after the address and drives one when it has nothing to send. A controller that samples one pulse early would therefore return the word shifted right with a zero on top. The bench uses a 6-bit request with the top address bits set to show that these bits never reach the line. A design that sent them, or sent the wrong length, would make the model decode another address and return a different word. It also uses words of all zeros and all ones, and repeated start requests mid-transaction that would restart or corrupt a careless sequencer. It also asserts reset mid-read, after which the pins must drop at once and a fresh read must succeed. Every cycle is compared against a reference waveform, so a phase that is one cycle short or long, a missing leading or trailing pulse, or an output change inside a pulse shows up at the exact cycle.

// File: rtl/sprom_rd_pkg.sv
package sprom_rd_pkg;

  // Command prefix: start bit then read opcode, sent left to right.
  localparam int unsigned CMD_W = 3;
  localparam logic [CMD_W-1:0] RD_CMD = 3'b110;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SEL,
    PH_PRE_HI,
    PH_PRE_LO,
    PH_BIT_SET,
    PH_BIT_HI,
    PH_BIT_LO,
    PH_DO_LOW,
    PH_RD_HI,
    PH_RD_LO,
    PH_DESEL,
    PH_POST_HI,
    PH_POST_LO
  } phase_e;

  typedef struct packed {
    logic sel;
    logic sclk;
    logic sout;
  } pins_t;

  function automatic pins_t pins_of(phase_e ph, logic bit_v);
    pins_t p;
    p.sel  = (ph inside {PH_SEL, PH_PRE_HI, PH_PRE_LO, PH_BIT_SET, PH_BIT_HI,
                         PH_BIT_LO, PH_DO_LOW, PH_RD_HI, PH_RD_LO});
    p.sclk = (ph inside {PH_PRE_HI, PH_BIT_HI, PH_RD_HI, PH_POST_HI});
    p.sout = (ph inside {PH_BIT_SET, PH_BIT_HI, PH_BIT_LO}) && bit_v;
    return p;
  endfunction

endpackage

// File: rtl/sprom_rst_sync.sv
module sprom_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_no = stg_q[1];

endmodule

// File: rtl/sprom_phase_timer.sv
module sprom_phase_timer #(
  parameter int unsigned PHASE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic adv_o
);

  localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;
  logic             cnt_en;

  assign at_end = (cnt_q == CNT_END);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i || at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign adv_o = run_i && at_end;

  AST_TIMER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END); // R7

  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> cnt_q == '0); // R7

endmodule

// File: rtl/sprom_tx_frame.sv
module sprom_tx_frame
  import sprom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned ADDR_W_SMALL = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              large_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              bit_next_o,
  output logic              last_o
);

  localparam int unsigned FRAME_W = CMD_W + ADDR_W;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);
  localparam int unsigned PAD_W   = ADDR_W - ADDR_W_SMALL;
  localparam logic [LEFT_W-1:0] LEN_LARGE = LEFT_W'(FRAME_W);
  localparam logic [LEFT_W-1:0] LEN_SMALL = LEFT_W'(CMD_W + ADDR_W_SMALL);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [FRAME_W-1:0] frame_large, frame_small;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               frame_en;

  assign frame_large = {RD_CMD, addr_i};

  // The short address is left-aligned so both sizes shift from the same MSB.
  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_small = {RD_CMD, addr_i[ADDR_W_SMALL-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame_small = frame_large;
    end
  endgenerate

  assign frame_en = load_i || shift_i;

  always_comb begin
    frame_d = frame_q;
    left_d  = left_q;
    if (load_i) begin
      frame_d = large_i ? frame_large : frame_small;
      left_d  = large_i ? LEN_LARGE : LEN_SMALL;
    end else if (shift_i) begin
      frame_d = frame_q << 1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (frame_en) begin
      frame_q <= frame_d;
      left_q  <= left_d;
    end
  end

  assign bit_next_o = frame_d[FRAME_W-1];
  assign last_o     = (left_q == LEFT_W'(1));

  AST_SHIFT_HAS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> left_q != '0); // R2

  AST_LOAD_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (left_q == LEN_LARGE) || (left_q == LEN_SMALL)); // R2

endmodule

// File: rtl/sprom_rx_word.sv
module sprom_rx_word #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              last_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = clear_i || cap_i;

  always_comb begin
    if (clear_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (cap_i) begin
      sh_q <= {sh_q[DATA_W-2:0], bit_i};
    end
  end

  assign word_o = sh_q;
  assign last_o = (cnt_q == CNT_W'(DATA_W - 1));

  AST_RX_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> cnt_q < CNT_W'(DATA_W)); // R5

  AST_RX_NO_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_i && clear_i)); // R5

endmodule

// File: rtl/sprom_seq_fsm.sv
module sprom_seq_fsm
  import sprom_rd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   adv_i,
  input  logic   frame_last_i,
  input  logic   rx_last_i,
  output phase_e phase_o,
  output phase_e phase_next_o,
  output logic   accept_o,
  output logic   shift_o,
  output logic   cap_o,
  output logic   finish_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start_i) phase_d = PH_SEL;
      PH_SEL:     if (adv_i)   phase_d = PH_PRE_HI;
      PH_PRE_HI:  if (adv_i)   phase_d = PH_PRE_LO;
      PH_PRE_LO:  if (adv_i)   phase_d = PH_BIT_SET;
      PH_BIT_SET: if (adv_i)   phase_d = PH_BIT_HI;
      PH_BIT_HI:  if (adv_i)   phase_d = PH_BIT_LO;
      PH_BIT_LO:  if (adv_i)   phase_d = frame_last_i ? PH_DO_LOW : PH_BIT_SET;
      PH_DO_LOW:  if (adv_i)   phase_d = PH_RD_HI;
      PH_RD_HI:   if (adv_i)   phase_d = PH_RD_LO;
      PH_RD_LO:   if (adv_i)   phase_d = rx_last_i ? PH_DESEL : PH_RD_HI;
      PH_DESEL:   if (adv_i)   phase_d = PH_POST_HI;
      PH_POST_HI: if (adv_i)   phase_d = PH_POST_LO;
      PH_POST_LO: if (adv_i)   phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o      = phase_q;
  assign phase_next_o = phase_d;
  assign accept_o     = (phase_q == PH_IDLE) && start_i;
  assign shift_o      = (phase_q == PH_BIT_LO) && adv_i;
  assign cap_o        = (phase_q == PH_RD_LO) && adv_i;
  assign finish_o     = (phase_q == PH_POST_LO) && adv_i;

  AST_PHASE_WAITS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && !adv_i) |=> phase_q == $past(phase_q)); // R7

  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_POST_LO) |=> phase_q != PH_IDLE); // R9

endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
  import sprom_rd_pkg::*;
#(
  parameter int unsigned PHASE_CYC    = 4,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned ADDR_W_SMALL = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dev_large_i,
  input  logic              ser_in_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ser_sel_o,
  output logic              ser_clk_o,
  output logic              ser_out_o
);

  logic              rst_n_s;
  logic              adv;
  phase_e            phase_q, phase_d;
  logic              accept, shift, cap, finish;
  logic              frame_last, bit_next, rx_last;
  logic [DATA_W-1:0] rx_word;
  pins_t             pins_d, pins_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  sprom_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  sprom_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (phase_q != PH_IDLE),
    .adv_o  (adv)
  );

  sprom_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .start_i      (start_i),
    .adv_i        (adv),
    .frame_last_i (frame_last),
    .rx_last_i    (rx_last),
    .phase_o      (phase_q),
    .phase_next_o (phase_d),
    .accept_o     (accept),
    .shift_o      (shift),
    .cap_o        (cap),
    .finish_o     (finish)
  );

  sprom_tx_frame #(.ADDR_W(ADDR_W), .ADDR_W_SMALL(ADDR_W_SMALL)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .load_i     (accept),
    .large_i    (dev_large_i),
    .addr_i     (addr_i),
    .shift_i    (shift),
    .bit_next_o (bit_next),
    .last_o     (frame_last)
  );

  sprom_rx_word #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .clear_i (accept),
    .cap_i   (cap),
    .bit_i   (ser_in_i),
    .word_o  (rx_word),
    .last_o  (rx_last)
  );

  // Serial pins are registered from the next phase so they stay glitch-free
  // and still line up cycle for cycle with the phase register.
  assign pins_d = pins_of(phase_d, bit_next);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pins_q <= '0;
    end else begin
      pins_q <= pins_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q <= '0;
    end else if (finish) begin
      data_q <= rx_word;
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign ser_sel_o = pins_q.sel;
  assign ser_clk_o = pins_q.sclk;
  assign ser_out_o = pins_q.sout;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    done_o |=> !done_o); // R8

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    done_o |-> !busy_o && !ser_sel_o && !ser_clk_o); // R8

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !done_o |-> $stable(data_o)); // R8

  AST_OUT_STILL_NEAR_CLK: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ser_clk_o || $past(ser_clk_o)) |-> $stable(ser_out_o)); // R4

  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!busy_o && !$past(busy_o)) |-> !ser_sel_o && !ser_clk_o && !ser_out_o); // R10

  AST_SEL_BEFORE_CLK: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(ser_sel_o) |-> !ser_clk_o && !ser_out_o); // R3

endmodule

// File: tb/sprom_word_reader_bench.sv
`timescale 1ns/1ps
module sprom_word_reader_bench;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       dev_large = 1'b0;
  logic       ser_in = 1'b1;
  logic       busy, done, sel, sclk, sout;
  logic [15:0] data;

  always #2.5 clk = ~clk;

  sprom_word_reader #(.PHASE_CYC(P), .DATA_W(16), .ADDR_W(8), .ADDR_W_SMALL(6)) u_sprom_word_reader (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .addr_i      (addr),
    .dev_large_i (dev_large),
    .ser_in_i    (ser_in),
    .busy_o      (busy),
    .done_o      (done),
    .data_o      (data),
    .ser_sel_o   (sel),
    .ser_clk_o   (sclk),
    .ser_out_o   (sout)
  );

  int checks = 0;
  int errors = 0;

  // Reference waveform: {busy, done, sel, sclk, sout} per cycle.
  logic [4:0]  exp_q[$];
  string       tag_q[$];
  logic [15:0] held_word = 16'h0000;
  logic [15:0] exp_word;
  logic [7:0]  exp_adr;
  string       adr_tag;
  int          busy_cnt = 0;
  int          exp_len = 0;

  function automatic logic [15:0] mem_word(logic [7:0] a, int alen);
    if (a == 8'h00) return 16'h0000;
    if (int'(a) == (1 << alen) - 1) return 16'hFFFF;
    return 16'(int'(a) * 40503) ^ 16'h5AC3 ^ ((alen == 8) ? 16'h0F0F : 16'h0000);
  endfunction

  // Memory model: waits for a start bit, takes opcode and address, then
  // drives a dummy zero followed by the word, MSB first, on clock rises.
  int          dev_alen = 6;
  logic        dev_on = 1'b0;
  int          dev_n = 0;
  logic [9:0]  dev_cmd = '0;
  logic [15:0] dev_word = '0;
  int          dev_oidx = 0;
  logic [1:0]  got_opc = '0;
  logic [7:0]  got_adr = '0;

  always @(posedge sclk or negedge sel) begin
    if (!sel) begin
      dev_on   = 1'b0;
      dev_n    = 0;
      dev_oidx = 0;
      ser_in   = 1'b1;
    end else if (!dev_on) begin
      if (sout) begin
        dev_on  = 1'b1;
        dev_n   = 0;
        dev_cmd = '0;
      end
    end else if (dev_n < 2 + dev_alen) begin
      dev_cmd = {dev_cmd[8:0], sout};
      dev_n++;
      if (dev_n == 2 + dev_alen) begin
        got_opc  = 2'(dev_cmd >> dev_alen);
        got_adr  = 8'(dev_cmd & 10'((1 << dev_alen) - 1));
        dev_word = mem_word(got_adr, dev_alen);
        dev_oidx = 16;
        ser_in   = 1'b0;
      end
    end else if (dev_oidx > 0) begin
      ser_in = dev_word[dev_oidx-1];
      dev_oidx--;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 40)
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic check_cycle();
    logic [4:0] e;
    logic [4:0] g;
    string      t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = 5'b00000;
      t = "R10";
    end
    g = {busy, done, sel, sclk, sout};
    chk(g === e, t, "pins {busy,done,sel,clk,out}", 32'(g), 32'(e));
    if (g[4] === 1'b1) busy_cnt++;
    if (e[3]) begin
      chk(data === exp_word, "R5", "read word", 32'(data), 32'(exp_word));
      chk(got_opc === 2'b10, "R1", "opcode bits", 32'(got_opc), 32'h2);
      chk(got_adr === exp_adr, adr_tag, "address seen by memory", 32'(got_adr), 32'(exp_adr));
      chk(busy_cnt == exp_len, "R7", "busy cycles", 32'(busy_cnt), 32'(exp_len));
      held_word = exp_word;
    end else if (exp_q.size() == 0) begin
      chk(data === held_word, "R8", "held data", 32'(data), 32'(held_word));
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_cycle();
  endtask

  task automatic push_phase(logic c, logic k, logic o, string t);
    for (int i = 0; i < P; i++) begin
      exp_q.push_back({1'b1, 1'b0, c, k, o});
      tag_q.push_back(t);
    end
  endtask

  task automatic push_bit(logic b, string t);
    push_phase(1'b1, 1'b0, b, "R4");
    push_phase(1'b1, 1'b1, b, t);
    push_phase(1'b1, 1'b0, b, t);
  endtask

  task automatic launch(logic [7:0] a, logic lg, string atag);
    int alen;
    alen      = lg ? 8 : 6;
    start     = 1'b1;
    addr      = a;
    dev_large = lg;
    dev_alen  = alen;
    exp_adr   = lg ? a : (a & 8'h3F);
    exp_word  = mem_word(exp_adr, alen);
    adr_tag   = atag;
    busy_cnt  = 0;
    exp_len   = P * (48 + 3 * alen);
    push_phase(1'b1, 1'b0, 1'b0, "R3");   // R3 select setup
    push_phase(1'b1, 1'b1, 1'b0, "R3");   // R3 leading pulse
    push_phase(1'b1, 1'b0, 1'b0, "R3");
    push_bit(1'b1, "R1");                 // R1 start bit
    push_bit(1'b1, "R1");
    push_bit(1'b0, "R1");
    for (int i = alen - 1; i >= 0; i--) push_bit(exp_adr[i], "R2");
    push_phase(1'b1, 1'b0, 1'b0, "R5");   // R5 output low before read
    for (int i = 0; i < 16; i++) begin
      push_phase(1'b1, 1'b1, 1'b0, "R5");
      push_phase(1'b1, 1'b0, 1'b0, "R5");
    end
    push_phase(1'b0, 1'b0, 1'b0, "R6");   // R6 release select
    push_phase(1'b0, 1'b1, 1'b0, "R6");   // R6 trailing pulse
    push_phase(1'b0, 1'b0, 1'b0, "R6");
    exp_q.push_back(5'b01000);            // R8 done pulse
    tag_q.push_back("R8");
    step();
    start = 1'b0;
  endtask

  task automatic run_out();
    while (exp_q.size() > 0) step();
    repeat (3) step();
  endtask

  task automatic finish_sim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    finish_sim();
  end

  initial begin
    // R10 reset state
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R2 short part, then short part with upper address bits set
    launch(8'h15, 1'b0, "R2");
    run_out();
    launch(8'hEA, 1'b0, "R2");
    run_out();

    // R2 large part, plus all-zero and all-ones words
    launch(8'hA7, 1'b1, "R2");
    run_out();
    launch(8'h00, 1'b1, "R2");
    run_out();
    launch(8'hFF, 1'b1, "R2");
    run_out();
    launch(8'h3F, 1'b0, "R2");
    run_out();

    // R9 start requests with other settings during a read
    launch(8'h5C, 1'b1, "R9");
    repeat (20) step();
    start = 1'b1; addr = 8'h13; dev_large = 1'b0;
    step(); step();
    start = 1'b0;
    repeat (150) step();
    start = 1'b1; addr = 8'hC1; dev_large = 1'b0;
    step();
    start = 1'b0; dev_large = 1'b1;
    run_out();

    // R10 reset in the middle of a read, then recovery
    launch(8'h33, 1'b1, "R2");
    repeat (100) step();
    rst_n = 1'b0;
    exp_q.delete();
    tag_q.delete();
    held_word = 16'h0000;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    launch(8'h2D, 1'b0, "R2");
    run_out();

    finish_sim();
  end

endmodule